// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiplier

This block executes the integer multiply group of a 64-bit core: the low product, three high-product variants that differ in how each operand's sign is treated, and a 32-bit word multiply whose result is sign-extended. A caller presents two 64-bit operands, a 3-bit operation code and a word flag, and pulses `start_i` for one cycle. Exactly three clock edges later, `done_o` is high for one cycle and `result_o` carries the value for the destination register. A new `start_i` may be issued on every cycle. Results leave in issue order.

Inside, the operands are reduced to unsigned magnitudes. Four half-width partial products are formed and then combined into a 128-bit magnitude product. When a high result must be negative, the product is negated in two's complement across all 128 bits. The high half is inverted. It takes the +1 only when the low half of the magnitude product is all zeros.

Top module: `mul_unit`

## Requirements
- R1: During reset, and after it until the first completion, `done_o` is 0 and `result_o` is 0.
- R2: With `word_i`=0 and `op_i`=0, the result is bits [63:0] of the product of a and b.
- R3: With `word_i`=0 and `op_i`=1, the result is bits [127:64] of the product of signed a and signed b.
- R4: With `word_i`=0 and `op_i`=2, the result is bits [127:64] of the product of signed a and unsigned b.
- R5: With `word_i`=0 and `op_i`=3, the result is bits [127:64] of the product of unsigned a and unsigned b.
- R6: With `word_i`=1, the result is bits [31:0] of a×b, sign-extended from bit 31 to 64 bits. Bits [63:32] of both operands have no effect.
- R7: With `word_i`=1, `op_i` has no effect. All eight codes give the R6 result.
- R8: `done_o` is high for exactly one cycle. It is high at the third rising edge after the edge that samples `start_i` high, and at no other time.
- R9: `result_o` holds its value while `done_o` is low.
- R10: With `word_i`=0, codes 4 to 7 return the low product, the same as code 0.
- R11: An operand equal to the most negative 64-bit value, 0x8000_0000_0000_0000, has magnitude 2^63 in the signed high forms. The results match the 128-bit reference.
- R12: When starts are issued on consecutive cycles, each result appears on consecutive cycles in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue one operation |
| op_i | input | 3 | Operation code: 0 low, 1 signed high, 2 signed×unsigned high, 3 unsigned high |
| word_i | input | 1 | 32-bit word multiply, sign-extended |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| done_o | output | 1 | Result valid, one cycle |
| result_o | output | 64 | Destination value, held until the next completion |

## Verification
A fault in the partial-product combine shows up as a wrong high half, but only for operands whose middle products carry. The reference comparison therefore mixes random operands with all-ones values. An error in the negation's carry decision only shows up on signed high results where the low half of the product is zero or non-zero. Zero, ±1 and the most negative value exercise that case. Any corrupted pipeline stage reaches `result_o` three edges after the start, so the bench compares at that cycle and checks that the held value stays stable afterwards.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned HALF = XLEN / 2;

  typedef enum logic [2:0] {
    MOP_LO  = 3'd0,
    MOP_HSS = 3'd1,
    MOP_HSU = 3'd2,
    MOP_HUU = 3'd3
  } mul_op_e;
endpackage

// File: rtl/mul_sign_prep.sv
module mul_sign_prep #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  input  logic         word_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o,
  output logic         sel_hi_o
);
  import mul_pkg::*;
  logic a_sgn, b_sgn;

  always_comb begin
    sel_hi_o = !word_i && !op_i[2] && (op_i[1:0] != 2'd0);
    a_sgn    = sel_hi_o && (op_i == MOP_HSS || op_i == MOP_HSU) && a_i[W-1];
    b_sgn    = sel_hi_o && (op_i == MOP_HSS) && b_i[W-1];
    // unsigned negate: most negative value maps to 2^(W-1) exactly
    mag_a_o  = a_sgn ? (~a_i + 1'b1) : a_i;
    mag_b_o  = b_sgn ? (~b_i + 1'b1) : b_i;
    neg_o    = a_sgn ^ b_sgn;
  end
endmodule

// File: rtl/mul_part_array.sv
module mul_part_array #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]        mag_a_i,
  input  logic [W-1:0]        mag_b_i,
  output logic [3:0][W-1:0]   pp_o
);
  localparam int unsigned H = W / 2;

  logic [1:0][H-1:0] a_h, b_h;
  assign a_h = mag_a_i;
  assign b_h = mag_b_i;

  // pp index {i,j}: a half i times b half j (0 = low)
  for (genvar i = 0; i < 2; i++) begin : g_ai
    for (genvar j = 0; j < 2; j++) begin : g_bj
      assign pp_o[i*2+j] = {{H{1'b0}}, a_h[i]} * {{H{1'b0}}, b_h[j]};
    end
  end
endmodule

// File: rtl/mul_combine.sv
module mul_combine #(
  parameter int unsigned W = 64
) (
  input  logic [3:0][W-1:0] pp_i,
  input  logic              neg_i,
  input  logic              sel_hi_i,
  input  logic              word_i,
  output logic [W-1:0]      res_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] ll, lh, hl, hh;
  logic [H+1:0] mid;
  logic [W-1:0] lo_m, hi_m, lo_f, hi_f;

  always_comb begin
    ll   = pp_i[0];
    lh   = pp_i[1];
    hl   = pp_i[2];
    hh   = pp_i[3];
    mid  = {2'b00, hl[H-1:0]} + {2'b00, lh[H-1:0]} + {2'b00, ll[W-1:H]};
    lo_m = {mid[H-1:0], ll[H-1:0]};
    hi_m = hh + (hl >> H) + (lh >> H) + {{(W-2){1'b0}}, mid[H+1:H]};
    if (neg_i) begin
      lo_f = ~lo_m + 1'b1;
      // carry out of the low half only when it was all zeros
      hi_f = ~hi_m + {{(W-1){1'b0}}, (lo_m == '0)};
    end else begin
      lo_f = lo_m;
      hi_f = hi_m;
    end
    if (word_i)        res_o = {{H{lo_f[H-1]}}, lo_f[H-1:0]};
    else if (sel_hi_i) res_o = hi_f;
    else               res_o = lo_f;
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic         word_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic [W-1:0]      mag_a_d, mag_b_d;
  logic              neg_d, sel_hi_d;
  logic [W-1:0]      mag_a_q, mag_b_q;
  logic              s1_v_q, s1_neg_q, s1_hi_q, s1_word_q;
  logic [3:0][W-1:0] pp_d, pp_q;
  logic              s2_v_q, s2_neg_q, s2_hi_q, s2_word_q;
  logic [W-1:0]      res_d;

  mul_sign_prep #(.W(W)) u_prep (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .word_i(word_i),
    .mag_a_o(mag_a_d), .mag_b_o(mag_b_d), .neg_o(neg_d), .sel_hi_o(sel_hi_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q <= 1'b0; s1_neg_q <= 1'b0; s1_hi_q <= 1'b0; s1_word_q <= 1'b0;
      mag_a_q <= '0; mag_b_q <= '0;
    end else begin
      s1_v_q <= start_i;
      if (start_i) begin
        mag_a_q <= mag_a_d; mag_b_q <= mag_b_d;
        s1_neg_q <= neg_d; s1_hi_q <= sel_hi_d; s1_word_q <= word_i;
      end
    end
  end

  mul_part_array #(.W(W)) u_parts (
    .mag_a_i(mag_a_q), .mag_b_i(mag_b_q), .pp_o(pp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v_q <= 1'b0; s2_neg_q <= 1'b0; s2_hi_q <= 1'b0; s2_word_q <= 1'b0;
      pp_q <= '0;
    end else begin
      s2_v_q <= s1_v_q;
      if (s1_v_q) begin
        pp_q <= pp_d;
        s2_neg_q <= s1_neg_q; s2_hi_q <= s1_hi_q; s2_word_q <= s1_word_q;
      end
    end
  end

  mul_combine #(.W(W)) u_comb (
    .pp_i(pp_q), .neg_i(s2_neg_q), .sel_hi_i(s2_hi_q), .word_i(s2_word_q),
    .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= s2_v_q;
      if (s2_v_q) result_o <= res_d;
    end
  end
endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic         word_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int unsigned H = W / 2;

  // R8
  done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 3));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R2
  low_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(op_i, 3) == 3'd0 && !$past(word_i, 3)) |->
      result_o == W'($past(a_i, 3) * $past(b_i, 3)));

  // R5
  hi_uu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(op_i, 3) == 3'd3 && !$past(word_i, 3)) |->
      result_o == W'(({{W{1'b0}}, $past(a_i, 3)} * {{W{1'b0}}, $past(b_i, 3)}) >> W));

  // R6
  word_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(word_i, 3)) |-> result_o[W-1:H] == {H{result_o[H-1]}});
endmodule

bind mul_unit mul_unit_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .word_i(word_i), .a_i(a_i), .b_i(b_i), .done_o(done_o), .result_o(result_o)
);

// File: tb/tb_mul_unit.sv
`timescale 1ns/1ps
module tb_mul_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        done_o;
  logic [63:0] result_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  mul_unit dut (.*);

  function automatic logic [63:0] ref_res(logic [2:0] op, logic wd,
                                          logic [63:0] a, logic [63:0] b);
    logic [127:0] sa, sb, ua, ub, p;
    sa = {{64{a[63]}}, a}; sb = {{64{b[63]}}, b};
    ua = {64'd0, a};       ub = {64'd0, b};
    if (wd) begin
      p = ua * ub;
      return {{32{p[31]}}, p[31:0]};
    end
    case (op)
      3'd1: p = sa * sb;
      3'd2: p = sa * ub;
      3'd3: p = ua * ub;
      default: begin p = ua * ub; return p[63:0]; end
    endcase
    return p[127:64];
  endfunction

  function automatic string tag_of(logic [2:0] op, logic wd,
                                   logic [63:0] a, logic [63:0] b);
    if (wd) return (op != 3'd0) ? "R7" : "R6";
    if (op[2]) return "R10";
    if (op != 3'd0 && (a == 64'h8000_0000_0000_0000 || b == 64'h8000_0000_0000_0000))
      return "R11";
    case (op[1:0])
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one op; sample at negedge after the third edge
  task automatic run_one(logic [2:0] op, logic wd, logic [63:0] a, logic [63:0] b);
    logic [63:0] exp;
    exp = ref_res(op, wd, a, b);
    start_i = 1'b1; op_i = op; word_i = wd; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0; a_i = $urandom; b_i = $urandom; op_i = 3'($urandom);
    @(negedge clk_i);
    check("R8", {63'd0, done_o}, 64'd0);
    @(negedge clk_i);
    check("R8", {63'd0, done_o}, 64'd1);
    check(tag_of(op, wd, a, b), result_o, exp);
    @(negedge clk_i);
    check("R8", {63'd0, done_o}, 64'd0);
    check("R9", result_o, exp);
  endtask

  logic [63:0] corner [8];

  initial begin
    logic [63:0] ra, rb, hi_junk;
    logic [63:0] e0, e1, e2;
    void'($urandom(32'd1234));
    corner[0] = 64'd0;                  corner[1] = 64'd1;
    corner[2] = 64'hFFFF_FFFF_FFFF_FFFF; corner[3] = 64'h8000_0000_0000_0000;
    corner[4] = 64'h7FFF_FFFF_FFFF_FFFF; corner[5] = 64'h0000_0001_0000_0000;
    corner[6] = 64'hFFFF_FFFF_0000_0000; corner[7] = 64'h0000_0000_FFFF_FFFF;

    repeat (3) @(negedge clk_i);
    check("R1", {63'd0, done_o}, 64'd0);
    check("R1", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {63'd0, done_o}, 64'd0);
    check("R1", result_o, 64'd0);

    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int op = 0; op < 4; op++)
          run_one(3'(op), 1'b0, corner[i], corner[j]);

    for (int k = 0; k < 8; k++) begin
      run_one(3'(k), 1'b1, corner[k], corner[(k + 3) % 8]);
      run_one(3'(k), 1'b0, corner[k], corner[(k + 5) % 8]);
    end

    // R6: upper operand bits have no effect in word mode
    for (int k = 0; k < 20; k++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      hi_junk = {$urandom, 32'd0};
      run_one(3'd0, 1'b1, ra ^ hi_junk, rb);
      check("R6", result_o, ref_res(3'd0, 1'b1, {32'd0, ra[31:0]}, {32'd0, rb[31:0]}));
    end

    for (int k = 0; k < 300; k++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      if (k % 7 == 0) ra = -ra;
      run_one(3'($urandom % 8), 1'(($urandom % 5) == 0), ra, rb);
    end

    // R12: three back-to-back issues
    e0 = ref_res(3'd1, 1'b0, corner[3], corner[2]);
    e1 = ref_res(3'd2, 1'b0, corner[2], corner[2]);
    e2 = ref_res(3'd0, 1'b1, corner[4], corner[4]);
    start_i = 1'b1; op_i = 3'd1; word_i = 1'b0; a_i = corner[3]; b_i = corner[2];
    @(negedge clk_i);
    op_i = 3'd2; a_i = corner[2]; b_i = corner[2];
    @(negedge clk_i);
    op_i = 3'd0; word_i = 1'b1; a_i = corner[4]; b_i = corner[4];
    @(negedge clk_i);
    start_i = 1'b0; word_i = 1'b0;
    check("R12", {63'd0, done_o}, 64'd1);
    check("R12", result_o, e0);
    @(negedge clk_i);
    check("R12", {63'd0, done_o}, 64'd1);
    check("R12", result_o, e1);
    @(negedge clk_i);
    check("R12", {63'd0, done_o}, 64'd1);
    check("R12", result_o, e2);
    @(negedge clk_i);
    check("R12", {63'd0, done_o}, 64'd0);
    check("R9", result_o, e2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule